// File: doc/BRIEF.md
# Interrupt Status Controller

The block gathers event signals from receiver functions into two 8-bit status registers. Each status register has a matching 8-bit enable register. The active-low request output `irq_n` is low whenever any status bit is set and its enable bit is also set. The host releases the request by reading a status register: the read returns the register's contents and clears the bits that latch events. Control and status pins are plain strobes and levels. There is no streaming interface, so no valid/ready back-pressure applies.

Each status bit behaves in one of three ways, chosen per bit by a parameter mask:

- **Latched bits** capture single-cycle pulses and are cleared by a read of their register.
- **Level bits** copy their input, one cycle late. With the default masks these are status register 1, bits 7 and 6: the sync-found and preamble-valid indications, which stay high until the packet is finished.
- **The FIFO error bit** latches like an event, but only a `fifo_clr` pulse clears it. With the default masks this is status register 0, bit 7.

Register map, selected by `reg_addr`:

| Address | Register |
|---|---|
| 0 | status 0 |
| 1 | status 1 |
| 2 | enable 0 |
| 3 | enable 1 |

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset every status bit is 0, enable 0 reads 0x00, enable 1 reads 0x03, `irq_n` is 1 and `reg_rdata` is 0.
- R2: A pulse on a latched bit of `evt_in` (bit index 8*reg + bit) sets that status bit at the next clock edge, and the bit stays set until it is cleared.
- R3: `irq_n` is 0 exactly when some status bit and its enable bit are both 1; it changes in the same cycle as the status or enable register changes.
- R4: Status bits whose enable bit is 0 still record events and read back as set, but they leave `irq_n` at 1.
- R5: When `reg_rd` is high with `reg_addr` 0 or 1, `reg_rdata` shows that status register's value from before the read, one cycle later. The read clears only the latched bits of the register addressed.
- R6: An event on a latched bit in the same cycle as a clearing read of its register leaves the bit set. That event is not part of the data returned by the read.
- R7: Level bits (status 1 bits 7 and 6) equal their `evt_in` bit from the previous cycle, and reads do not alter them.
- R8: The FIFO error bit (status 0 bit 7) is not cleared by reads. A `fifo_clr` pulse clears it, unless an error event arrives in the same cycle, in which case the bit stays set.
- R9: `reg_wr` with address 2 or 3 loads `reg_wdata` into that enable register, which reads back at the same address. Writes to addresses 0 and 1 are ignored.
- R10: Once reads have cleared all enabled pending bits, `irq_n` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_in | input | 16 | Event pulses for latched bits and level inputs for level bits, register-major |
| fifo_clr | input | 1 | FIFO reset pulse; clears the FIFO error bit |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after `reg_rd` |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Two pairs of functions can fall in the same clock cycle:

- A clearing read of a status register and a fresh event on a bit of that same register.
- A `fifo_clr` pulse and a new FIFO error event.

The bench provokes each collision in a directed step. For the first pair it checks that the returned data excludes the new event and that a second read shows it. For the second pair it checks that the error bit survives the clear. Random traffic then drives reads, writes, clears and events together, and every cycle is compared against a behavioural model.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned REG_W = 8;
  localparam int unsigned REG_N = 2;
  // status 1 bits 7:6 follow levels; status 0 bit 7 is the FIFO error bit
  localparam logic [REG_N*REG_W-1:0] LEVEL_DEF  = 16'hC000;
  localparam logic [REG_N*REG_W-1:0] STICKY_DEF = 16'h0080;
  localparam logic [REG_N*REG_W-1:0] EN_RST_DEF = 16'h0300;
endpackage

// File: rtl/irq_stat_bank.sv
module irq_stat_bank #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] LEVEL_MASK  = '0,
  parameter logic [W-1:0] STICKY_MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic         rd_clr,
  input  logic         fifo_clr,
  output logic [W-1:0] stat
);
  logic [W-1:0] clr_vec;
  logic [W-1:0] stat_nxt;

  always_comb begin
    // reads clear latched bits, the FIFO reset clears the sticky ones
    clr_vec  = ({W{rd_clr}} & ~STICKY_MASK) | ({W{fifo_clr}} & STICKY_MASK);
    // level bits drop their history; new events always win over a clear
    stat_nxt = (stat & ~clr_vec & ~LEVEL_MASK) | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat <= '0;
    else        stat <= stat_nxt;
  end
endmodule

// File: rtl/irq_en_bank.sv
module irq_en_bank #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  en <= RST_VAL;
    else if (wr) en <= wdata;
  end
endmodule

// File: rtl/irq_rd_port.sv
module irq_rd_port #(
  parameter int unsigned W    = 8,
  parameter int unsigned NREG = 2,
  parameter int unsigned AW   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd,
  input  logic [AW-1:0]   addr,
  input  logic [NREG*W-1:0] stat_all,
  input  logic [NREG*W-1:0] en_all,
  output logic [W-1:0]    rdata
);
  logic [W-1:0] sel_data;

  always_comb begin
    sel_data = '0;
    if (int'(addr) < int'(NREG))
      sel_data = stat_all[int'(addr)*W +: W];
    else if (int'(addr) < int'(2*NREG))
      sel_data = en_all[(int'(addr)-int'(NREG))*W +: W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (rd) rdata <= sel_data;
  end
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl #(
  parameter int unsigned W    = irq_pkg::REG_W,
  parameter int unsigned NREG = irq_pkg::REG_N,
  parameter logic [NREG*W-1:0] LEVEL_MASK  = irq_pkg::LEVEL_DEF,
  parameter logic [NREG*W-1:0] STICKY_MASK = irq_pkg::STICKY_DEF,
  parameter logic [NREG*W-1:0] EN_RST      = irq_pkg::EN_RST_DEF,
  localparam int unsigned AW = $clog2(2*NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NREG*W-1:0] evt_in,
  input  logic              fifo_clr,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [AW-1:0]     reg_addr,
  input  logic [W-1:0]      reg_wdata,
  output logic [W-1:0]      reg_rdata,
  output logic              irq_n
);
  logic [NREG*W-1:0] stat_all;
  logic [NREG*W-1:0] en_all;

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    logic rd_hit;
    logic wr_hit;
    assign rd_hit = reg_rd && (reg_addr == AW'(k));
    assign wr_hit = reg_wr && (reg_addr == AW'(NREG + k));

    irq_stat_bank #(
      .W(W),
      .LEVEL_MASK(LEVEL_MASK[k*W +: W]),
      .STICKY_MASK(STICKY_MASK[k*W +: W])
    ) u_stat (
      .clk(clk), .rst_n(rst_n),
      .evt(evt_in[k*W +: W]),
      .rd_clr(rd_hit),
      .fifo_clr(fifo_clr),
      .stat(stat_all[k*W +: W])
    );

    irq_en_bank #(
      .W(W),
      .RST_VAL(EN_RST[k*W +: W])
    ) u_en (
      .clk(clk), .rst_n(rst_n),
      .wr(wr_hit),
      .wdata(reg_wdata),
      .en(en_all[k*W +: W])
    );
  end

  irq_rd_port #(.W(W), .NREG(NREG), .AW(AW)) u_rd (
    .clk(clk), .rst_n(rst_n),
    .rd(reg_rd), .addr(reg_addr),
    .stat_all(stat_all), .en_all(en_all),
    .rdata(reg_rdata)
  );

  assign irq_n = ~|(stat_all & en_all);
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk #(
  parameter int unsigned W    = 8,
  parameter int unsigned NREG = 2,
  parameter logic [NREG*W-1:0] LEVEL_MASK  = '0,
  parameter logic [NREG*W-1:0] STICKY_MASK = '0,
  parameter int unsigned AW = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NREG*W-1:0] evt_in,
  input logic              fifo_clr,
  input logic              reg_rd,
  input logic              reg_wr,
  input logic [AW-1:0]     reg_addr,
  input logic              irq_n,
  input logic [NREG*W-1:0] stat_all,
  input logic [NREG*W-1:0] en_all
);
  // R2
  latch_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~stat_all & $past(evt_in) & ~LEVEL_MASK) == '0));

  // R7
  level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((stat_all ^ $past(evt_in)) & LEVEL_MASK) == '0));

  // R3
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr && (|(evt_in & en_all & ~LEVEL_MASK))) |=> !irq_n);

  // R8
  fifo_err_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_clr |=> ((~stat_all & $past(stat_all) & STICKY_MASK) == '0));

  // R9
  stat_wr_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && int'(reg_addr) < int'(NREG) && !reg_rd && !fifo_clr && evt_in == '0)
    |=> (((stat_all ^ $past(stat_all)) & ~LEVEL_MASK) == '0));

  for (genvar k = 0; k < NREG; k++) begin : g_chk
    // R5
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == AW'(k) && evt_in[k*W +: W] == '0)
      |=> ((stat_all[k*W +: W] & ~LEVEL_MASK[k*W +: W] & ~STICKY_MASK[k*W +: W]) == '0));
  end
endmodule

bind irq_status_ctrl irq_status_chk #(
  .W(W), .NREG(NREG), .LEVEL_MASK(LEVEL_MASK), .STICKY_MASK(STICKY_MASK), .AW(AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .fifo_clr(fifo_clr),
  .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr), .irq_n(irq_n),
  .stat_all(stat_all), .en_all(en_all)
);

// File: tb/sim_irq_status_ctrl.sv
module sim_irq_status_ctrl;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] evt_in = '0;
  logic        fifo_clr = 1'b0;
  logic        reg_rd = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        irq_n;

  logic [15:0] lvl_hold = '0;
  int nvec = 0;
  int nerr = 0;
  bit run = 0;
  bit done = 0;

  irq_status_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .fifo_clr(fifo_clr),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_n(irq_n)
  );

  always #(PERIOD/2) clk = ~clk;

  // behavioural reference: bit kinds as stated in R2, R7, R8
  localparam logic [15:0] LVL = 16'hC000;
  localparam logic [15:0] STK = 16'h0080;
  logic [7:0] m_st [2];
  logic [7:0] m_en [2];
  logic [7:0] m_rd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st[0] <= 8'h00; m_st[1] <= 8'h00;
      m_en[0] <= 8'h00; m_en[1] <= 8'h03;
      m_rd <= 8'h00;
    end else begin
      for (int k = 0; k < 2; k++) begin
        logic [7:0] nx;
        for (int b = 0; b < 8; b++) begin
          int i;
          i = k*8 + b;
          if (LVL[i])      nx[b] = evt_in[i];
          else if (STK[i]) nx[b] = (m_st[k][b] && !fifo_clr) || evt_in[i];
          else             nx[b] = (m_st[k][b] && !(reg_rd && reg_addr == 2'(k))) || evt_in[i];
        end
        m_st[k] <= nx;
        if (reg_wr && reg_addr == 2'(k+2)) m_en[k] <= reg_wdata;
      end
      if (reg_rd) m_rd <= reg_addr[1] ? m_en[reg_addr[0]] : m_st[reg_addr[0]];
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // R3 / R5: compared on every clock against the model
  always @(negedge clk) begin
    if (rst_n && run) begin
      chk("R3 irq_n vs model", {7'd0, irq_n},
          {7'd0, ~|((m_st[0] & m_en[0]) | (m_st[1] & m_en[1]))});
      chk("R5 rdata vs model", reg_rdata, m_rd);
    end
  end

  task automatic step(input logic [15:0] p, input logic rd, input logic wr,
                      input logic [1:0] a, input logic [7:0] d, input logic fc);
    evt_in = p | lvl_hold; reg_rd = rd; reg_wr = wr;
    reg_addr = a; reg_wdata = d; fifo_clr = fc;
    @(negedge clk);
    evt_in = lvl_hold; reg_rd = 0; reg_wr = 0; fifo_clr = 0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string tag);
    step(16'h0, 1'b1, 1'b0, a, 8'h0, 1'b0);
    chk(tag, reg_rdata, exp);
  endtask

  task automatic irq_chk(input logic exp, input string tag);
    chk(tag, {7'd0, irq_n}, {7'd0, exp});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD*200000);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    irq_chk(1'b1, "R1 irq_n after reset");
    chk("R1 rdata after reset", reg_rdata, 8'h00);
    run = 1;
    rd_chk(2'd3, 8'h03, "R1 enable1 reset");
    rd_chk(2'd2, 8'h00, "R1 enable0 reset");
    rd_chk(2'd0, 8'h00, "R1 status0 reset");

    // R4: disabled bit still records
    step(16'h0001, 0, 0, 0, 0, 0);
    irq_chk(1'b1, "R4 disabled bit no irq");
    rd_chk(2'd0, 8'h01, "R4 disabled bit recorded");

    // R2/R3: enabled bit raises irq, read releases it
    step(16'h0100, 0, 0, 0, 0, 0);
    irq_chk(1'b0, "R3 enabled event asserts irq");
    step(16'h0, 0, 0, 0, 0, 0);
    irq_chk(1'b0, "R2 bit holds until read");
    rd_chk(2'd1, 8'h01, "R5 status1 read");
    irq_chk(1'b1, "R10 irq released after read");

    // R9: enable writes, status writes ignored
    step(16'h0, 0, 1, 2'd2, 8'hFF, 0);
    rd_chk(2'd2, 8'hFF, "R9 enable0 write");
    step(16'h0, 0, 1, 2'd0, 8'h55, 0);
    rd_chk(2'd0, 8'h00, "R9 status write ignored");
    irq_chk(1'b1, "R9 irq after ignored write");

    // R6: event in the same cycle as the clearing read
    step(16'h0002, 0, 0, 0, 0, 0);
    irq_chk(1'b0, "R3 enable0 event");
    step(16'h0004, 1, 0, 2'd0, 0, 0);
    chk("R6 read excludes same-cycle event", reg_rdata, 8'h02);
    rd_chk(2'd0, 8'h04, "R6 same-cycle event kept");
    irq_chk(1'b1, "R10 irq released");

    // R5: read clears only its own register
    step(16'h0408, 0, 0, 0, 0, 0);
    rd_chk(2'd0, 8'h08, "R5 status0 only");
    rd_chk(2'd1, 8'h04, "R5 status1 untouched by status0 read");

    // R7: level bits
    lvl_hold = 16'h4000;
    step(16'h0, 0, 0, 0, 0, 0);
    rd_chk(2'd1, 8'h40, "R7 level high");
    rd_chk(2'd1, 8'h40, "R7 level survives read");
    lvl_hold = 16'h0000;
    step(16'h0, 0, 0, 0, 0, 0);
    rd_chk(2'd1, 8'h00, "R7 level low");

    // R8: FIFO error bit
    step(16'h0080, 0, 0, 0, 0, 0);
    rd_chk(2'd0, 8'h80, "R8 fifo err set");
    rd_chk(2'd0, 8'h80, "R8 fifo err survives read");
    irq_chk(1'b0, "R8 fifo err drives irq");
    step(16'h0, 0, 0, 0, 0, 1);
    rd_chk(2'd0, 8'h00, "R8 fifo_clr clears");
    step(16'h0080, 0, 0, 0, 0, 1);
    rd_chk(2'd0, 8'h80, "R8 event beats same-cycle clear");
    step(16'h0, 0, 0, 0, 0, 1);
    rd_chk(2'd0, 8'h00, "R8 cleared again");
    irq_chk(1'b1, "R10 all clear");

    // mixed random traffic, compared against the model every cycle
    for (int n = 0; n < 600; n++) begin
      logic [15:0] p;
      p = 16'($urandom) & 16'($urandom) & 16'($urandom);
      if ($urandom % 16 == 0) lvl_hold = 16'($urandom) & 16'hC000;
      step(p, ($urandom % 3) == 0, ($urandom % 6) == 0, 2'($urandom),
           8'($urandom), ($urandom % 10) == 0);
    end
    step(16'h0, 0, 0, 0, 0, 0);
    finish_run();
  end
endmodule